// File: doc/BRIEF.md
# DRAM Command Spacing Checker

This block watches a stream of DRAM commands on a memory controller's command path and flags any command that comes too soon after an earlier one. Each command names a bank, a bank group and a packed rank ID. The block keeps an elapsed-time counter for every command class it needs to remember, at bank, bank-group, logical-rank, physical-rank and whole-bus scope. It compares the selected counters against spacing limits. Some limits are primitive timing inputs. Others are sums of them, for example the write-recovery path or the row cycle.

Timing values are configuration inputs in clock cycles. The output is combinational: a flag, plus a code naming the broken rule, in the same cycle as the offending command. The block checks every command and blocks none. A monitor or an arbiter can use the flag.

Top module: `cmd_spacing_chk`

## Requirements
- R1: Command codes ACT=0, RD=1, WR=2, RDA=3, WRA=4 hold the shared command bus for two cycles. PREPB=5, PREAB=6 and REFAB=7 hold it for one. Any valid command in the cycle right after a two-cycle command, in any rank, reports code 1.
- R2: A second ACT must trail an earlier ACT by at least t_ras+t_rp on the same bank (code 2), t_rrd_l in the same bank group (code 3) and t_rrd_s in the same logical rank (code 4). ACTs in different logical ranks never conflict through these rules.
- R3: An ACT must trail a PREPB to the same bank by at least t_rp-1 (code 5). It must trail an RDA to the same bank by t_rtp+t_rp (code 6). It must trail a REFAB in the same logical rank by t_rfc-1 (code 7).
- R4: RD, WR, RDA or WRA must trail an ACT to the same bank by at least t_rcd (code 8).
- R5: A read (RD or RDA) after a write (WR or WRA) needs t_wl + burst + t_wtr_l in the same bank group (code 9) and t_wl + burst + t_wtr_s in the same logical rank (code 10). The burst is bl_i divided by DATA_RATE.
- R6: Read-to-read spacing is t_ccd_l in the same bank group (code 11) and t_ccd_s in the same logical rank (code 12). Write-to-write spacing is t_ccd_l_wr (code 13) and t_ccd_s_wr (code 14). RDA counts as a read and WRA as a write.
- R7: A PREPB needs t_ras+1 after an ACT (code 15), t_rtp+1 after an RD (code 16), and t_wl+burst+t_wr+1 after a WR (code 17), all on the same bank. RDA and WRA do not count for codes 16 and 17.
- R8: The rank ID is packed from bit 0 upward as logical rank, then physical rank, then DIMM rank, each field ceil(log2(count)) bits wide. Two precharges (PREPB or PREAB) in one physical rank must be spaced by t_ppd (code 18).
- R9: A command with no earlier relevant command in its scope never violates. Reset clears all history. A history older than the counter range counts as satisfied.
- R10: The flag and code are valid in the same cycle as cmd_valid_i. When several rules break at once, the lowest code is reported. With no violation, the code is 0. A cycle with cmd_valid_i low never flags and leaves the history unchanged.
- R11: A command that violates a rule is still recorded as the latest command for every scope it touches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| cmd_valid_i | input | 1 | a command is present this cycle |
| cmd_i | input | 3 | command code |
| rank_i | input | RW | packed rank ID |
| bg_i | input | BGW | bank group |
| bank_i | input | BKW | bank within group |
| t_rcd_i | input | CW | activate to column command |
| t_rp_i | input | CW | precharge period |
| t_ras_i | input | CW | activate to precharge |
| t_rrd_l_i | input | CW | ACT to ACT, same bank group |
| t_rrd_s_i | input | CW | ACT to ACT, same logical rank |
| t_rtp_i | input | CW | read to precharge |
| t_wl_i | input | CW | write latency |
| bl_i | input | CW | burst length in beats |
| t_wr_i | input | CW | write recovery |
| t_wtr_l_i | input | CW | write to read tail, same bank group |
| t_wtr_s_i | input | CW | write to read tail, other group |
| t_ccd_l_i | input | CW | read to read, same bank group |
| t_ccd_s_i | input | CW | read to read, same logical rank |
| t_ccd_l_wr_i | input | CW | write to write, same bank group |
| t_ccd_s_wr_i | input | CW | write to write, same logical rank |
| t_rfc_i | input | CW | refresh cycle |
| t_ppd_i | input | CW | precharge to precharge |
| viol_o | output | 1 | spacing violation this cycle |
| rule_o | output | 5 | code of the lowest broken rule, 0 if none |

## Verification
Each rule is driven with a command pair whose gap is swept from the bus minimum to one past the limit. This locates the exact cycle where the flag drops, which catches off-by-one errors in the derived sums. Each pair is placed at one scope level. Further pairs move the second command to a sibling bank, bank group, logical rank or physical rank, which shows that the right scope is decoded from the packed rank ID. Further sequences check code priority when rules overlap, idle cycles that carry a command code, the recording of violating commands, reset, and counter saturation.

// File: rtl/spc_pkg.sv
package spc_pkg;
  typedef enum logic [2:0] {
    CMD_ACT = 3'd0, CMD_RD = 3'd1, CMD_WR = 3'd2, CMD_RDA = 3'd3,
    CMD_WRA = 3'd4, CMD_PREPB = 3'd5, CMD_PREAB = 3'd6, CMD_REFAB = 3'd7
  } spc_cmd_e;

  localparam int NUM_SRC   = 14;
  localparam int NUM_RULES = 18;
  localparam int CODE_W    = 5;

  // selected history sources
  localparam int S_BUS    = 0;
  localparam int S_BK_ACT = 1;
  localparam int S_BK_PRE = 2;
  localparam int S_BK_RDA = 3;
  localparam int S_BK_RD  = 4;
  localparam int S_BK_WR  = 5;
  localparam int S_BG_ACT = 6;
  localparam int S_BG_RD  = 7;
  localparam int S_BG_WR  = 8;
  localparam int S_LR_ACT = 9;
  localparam int S_LR_RD  = 10;
  localparam int S_LR_WR  = 11;
  localparam int S_LR_REF = 12;
  localparam int S_PR_PRE = 13;

  localparam logic [7:0] M_ALL = 8'hFF;
  localparam logic [7:0] M_ACT = 8'b0000_0001;
  localparam logic [7:0] M_RDS = 8'b0000_1010;
  localparam logic [7:0] M_WRS = 8'b0001_0100;
  localparam logic [7:0] M_CAS = 8'b0001_1110;
  localparam logic [7:0] M_PPB = 8'b0010_0000;
  localparam logic [7:0] M_PRE = 8'b0110_0000;

  function automatic int rule_src(int code);
    case (code)
      1: return S_BUS;
      2: return S_BK_ACT;
      3: return S_BG_ACT;
      4: return S_LR_ACT;
      5: return S_BK_PRE;
      6: return S_BK_RDA;
      7: return S_LR_REF;
      8: return S_BK_ACT;
      9: return S_BG_WR;
      10: return S_LR_WR;
      11: return S_BG_RD;
      12: return S_LR_RD;
      13: return S_BG_WR;
      14: return S_LR_WR;
      15: return S_BK_ACT;
      16: return S_BK_RD;
      17: return S_BK_WR;
      default: return S_PR_PRE;
    endcase
  endfunction

  function automatic logic [7:0] rule_cmds(int code);
    case (code)
      1: return M_ALL;
      2, 3, 4, 5, 6, 7: return M_ACT;
      8: return M_CAS;
      9, 10, 11, 12: return M_RDS;
      13, 14: return M_WRS;
      15, 16, 17: return M_PPB;
      default: return M_PRE;
    endcase
  endfunction
endpackage

// File: rtl/spc_age_array.sv
module spc_age_array #(
  parameter int N  = 4,
  parameter int AW = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N-1:0]          hit_i,
  output logic [N-1:0][AW-1:0]  age_o
);
  // 0 = never seen, 1 = issued last cycle, saturates at all ones
  for (genvar g = 0; g < N; g++) begin : g_age
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 age_o[g] <= '0;
      else if (hit_i[g])                           age_o[g] <= AW'(1);
      else if (age_o[g] != '0 && age_o[g] != '1)   age_o[g] <= age_o[g] + AW'(1);
    end
  end
endmodule

// File: rtl/spc_limits.sv
module spc_limits
  import spc_pkg::*;
#(
  parameter int CW        = 8,
  parameter int LW        = 10,
  parameter int DATA_RATE = 2
) (
  input  logic [CW-1:0] t_rcd_i, t_rp_i, t_ras_i, t_rrd_l_i, t_rrd_s_i, t_rtp_i,
  input  logic [CW-1:0] t_wl_i, bl_i, t_wr_i, t_wtr_l_i, t_wtr_s_i,
  input  logic [CW-1:0] t_ccd_l_i, t_ccd_s_i, t_ccd_l_wr_i, t_ccd_s_wr_i,
  input  logic [CW-1:0] t_rfc_i, t_ppd_i,
  output logic [NUM_RULES-1:0][LW-1:0] lim_o
);
  localparam int SH = $clog2(DATA_RATE);

  function automatic logic [LW-1:0] ext(logic [CW-1:0] v);
    return LW'(v);
  endfunction
  function automatic logic [LW-1:0] dec(logic [CW-1:0] v);
    return (v == '0) ? '0 : LW'(v) - LW'(1);
  endfunction

  logic [LW-1:0] burst, wr_head;
  assign burst   = LW'(bl_i >> SH);
  assign wr_head = ext(t_wl_i) + burst;

  always_comb begin
    lim_o[0]  = LW'(2);
    lim_o[1]  = ext(t_ras_i) + ext(t_rp_i);
    lim_o[2]  = ext(t_rrd_l_i);
    lim_o[3]  = ext(t_rrd_s_i);
    lim_o[4]  = dec(t_rp_i);
    lim_o[5]  = ext(t_rtp_i) + ext(t_rp_i);
    lim_o[6]  = dec(t_rfc_i);
    lim_o[7]  = ext(t_rcd_i);
    lim_o[8]  = wr_head + ext(t_wtr_l_i);
    lim_o[9]  = wr_head + ext(t_wtr_s_i);
    lim_o[10] = ext(t_ccd_l_i);
    lim_o[11] = ext(t_ccd_s_i);
    lim_o[12] = ext(t_ccd_l_wr_i);
    lim_o[13] = ext(t_ccd_s_wr_i);
    lim_o[14] = ext(t_ras_i) + LW'(1);
    lim_o[15] = ext(t_rtp_i) + LW'(1);
    lim_o[16] = wr_head + ext(t_wr_i) + LW'(1);
    lim_o[17] = ext(t_ppd_i);
  end
endmodule

// File: rtl/spc_rule_eval.sv
module spc_rule_eval
  import spc_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic                          valid_i,
  input  logic [2:0]                    cmd_i,
  input  logic [NUM_SRC-1:0][AW-1:0]    age_i,
  input  logic [NUM_RULES-1:0][AW-1:0]  lim_i,
  output logic                          viol_o,
  output logic [CODE_W-1:0]             rule_o
);
  logic [NUM_RULES-1:0] brk;

  for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
    localparam int         SRC  = rule_src(r + 1);
    localparam logic [7:0] MASK = rule_cmds(r + 1);
    assign brk[r] = valid_i && MASK[cmd_i] && (age_i[SRC] != '0) && (age_i[SRC] < lim_i[r]);
  end

  // lowest code wins
  always_comb begin
    rule_o = '0;
    for (int r = NUM_RULES - 1; r >= 0; r--)
      if (brk[r]) rule_o = CODE_W'(r + 1);
  end
  assign viol_o = |brk;
endmodule

// File: rtl/cmd_spacing_chk.sv
module cmd_spacing_chk
  import spc_pkg::*;
#(
  parameter int BANKS_PER_BG = 2,
  parameter int NUM_BGS      = 2,
  parameter int LOG_RANKS    = 2,
  parameter int PHYS_RANKS   = 2,
  parameter int DIMM_RANKS   = 1,
  parameter int CW           = 8,
  parameter int AW           = 10,
  parameter int DATA_RATE    = 2,
  localparam int BKW = $clog2(BANKS_PER_BG),
  localparam int BGW = $clog2(NUM_BGS),
  localparam int LB  = $clog2(LOG_RANKS),
  localparam int RW  = LB + $clog2(PHYS_RANKS) + $clog2(DIMM_RANKS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  input  logic [2:0]      cmd_i,
  input  logic [RW-1:0]   rank_i,
  input  logic [BGW-1:0]  bg_i,
  input  logic [BKW-1:0]  bank_i,
  input  logic [CW-1:0]   t_rcd_i,
  input  logic [CW-1:0]   t_rp_i,
  input  logic [CW-1:0]   t_ras_i,
  input  logic [CW-1:0]   t_rrd_l_i,
  input  logic [CW-1:0]   t_rrd_s_i,
  input  logic [CW-1:0]   t_rtp_i,
  input  logic [CW-1:0]   t_wl_i,
  input  logic [CW-1:0]   bl_i,
  input  logic [CW-1:0]   t_wr_i,
  input  logic [CW-1:0]   t_wtr_l_i,
  input  logic [CW-1:0]   t_wtr_s_i,
  input  logic [CW-1:0]   t_ccd_l_i,
  input  logic [CW-1:0]   t_ccd_s_i,
  input  logic [CW-1:0]   t_ccd_l_wr_i,
  input  logic [CW-1:0]   t_ccd_s_wr_i,
  input  logic [CW-1:0]   t_rfc_i,
  input  logic [CW-1:0]   t_ppd_i,
  output logic            viol_o,
  output logic [4:0]      rule_o
);
  localparam int PRW = RW - LB;
  localparam int NLR = 1 << RW;
  localparam int NPR = 1 << PRW;
  localparam int NBG = 1 << (RW + BGW);
  localparam int NBK = 1 << (RW + BGW + BKW);
  localparam int K_BK = 5;
  localparam int K_BG = 3;
  localparam int K_LR = 4;

  int bk_idx, bg_idx, lr_idx, pr_idx;
  assign bk_idx = int'({rank_i, bg_i, bank_i});
  assign bg_idx = int'({rank_i, bg_i});
  assign lr_idx = int'(rank_i);
  assign pr_idx = int'(rank_i >> LB);

  logic is_act, is_rd, is_wr, is_rda, is_wra, is_ppb, is_pab, is_ref;
  assign is_act = cmd_valid_i && cmd_i == CMD_ACT;
  assign is_rd  = cmd_valid_i && cmd_i == CMD_RD;
  assign is_wr  = cmd_valid_i && cmd_i == CMD_WR;
  assign is_rda = cmd_valid_i && cmd_i == CMD_RDA;
  assign is_wra = cmd_valid_i && cmd_i == CMD_WRA;
  assign is_ppb = cmd_valid_i && cmd_i == CMD_PREPB;
  assign is_pab = cmd_valid_i && cmd_i == CMD_PREAB;
  assign is_ref = cmd_valid_i && cmd_i == CMD_REFAB;

  logic [K_BK-1:0] bk_kind;
  logic [K_BG-1:0] bg_kind;
  logic [K_LR-1:0] lr_kind;
  assign bk_kind = {is_wr, is_rd, is_rda, is_ppb, is_act};
  assign bg_kind = {is_wr | is_wra, is_rd | is_rda, is_act};
  assign lr_kind = {is_ref, is_wr | is_wra, is_rd | is_rda, is_act};

  logic [K_BK*NBK-1:0] bk_hit;
  logic [K_BG*NBG-1:0] bg_hit;
  logic [K_LR*NLR-1:0] lr_hit;
  logic [NPR-1:0]      pr_hit;
  logic [0:0]          bus_hit;

  always_comb begin
    for (int k = 0; k < K_BK; k++)
      for (int i = 0; i < NBK; i++) bk_hit[k*NBK+i] = bk_kind[k] && (i == bk_idx);
    for (int k = 0; k < K_BG; k++)
      for (int i = 0; i < NBG; i++) bg_hit[k*NBG+i] = bg_kind[k] && (i == bg_idx);
    for (int k = 0; k < K_LR; k++)
      for (int i = 0; i < NLR; i++) lr_hit[k*NLR+i] = lr_kind[k] && (i == lr_idx);
    for (int i = 0; i < NPR; i++) pr_hit[i] = (is_ppb || is_pab) && (i == pr_idx);
    bus_hit[0] = cmd_valid_i && (cmd_i <= CMD_WRA);
  end

  logic [K_BK*NBK-1:0][AW-1:0] bk_age;
  logic [K_BG*NBG-1:0][AW-1:0] bg_age;
  logic [K_LR*NLR-1:0][AW-1:0] lr_age;
  logic [NPR-1:0][AW-1:0]      pr_age;
  logic [0:0][AW-1:0]          bus_age;

  spc_age_array #(.N(K_BK*NBK), .AW(AW)) u_bk_age  (.clk_i, .rst_ni, .hit_i(bk_hit),  .age_o(bk_age));
  spc_age_array #(.N(K_BG*NBG), .AW(AW)) u_bg_age  (.clk_i, .rst_ni, .hit_i(bg_hit),  .age_o(bg_age));
  spc_age_array #(.N(K_LR*NLR), .AW(AW)) u_lr_age  (.clk_i, .rst_ni, .hit_i(lr_hit),  .age_o(lr_age));
  spc_age_array #(.N(NPR),      .AW(AW)) u_pr_age  (.clk_i, .rst_ni, .hit_i(pr_hit),  .age_o(pr_age));
  spc_age_array #(.N(1),        .AW(AW)) u_bus_age (.clk_i, .rst_ni, .hit_i(bus_hit), .age_o(bus_age));

  logic [NUM_SRC-1:0][AW-1:0] sel_age;
  always_comb begin
    sel_age[S_BUS]    = bus_age[0];
    sel_age[S_BK_ACT] = bk_age[0*NBK+bk_idx];
    sel_age[S_BK_PRE] = bk_age[1*NBK+bk_idx];
    sel_age[S_BK_RDA] = bk_age[2*NBK+bk_idx];
    sel_age[S_BK_RD]  = bk_age[3*NBK+bk_idx];
    sel_age[S_BK_WR]  = bk_age[4*NBK+bk_idx];
    sel_age[S_BG_ACT] = bg_age[0*NBG+bg_idx];
    sel_age[S_BG_RD]  = bg_age[1*NBG+bg_idx];
    sel_age[S_BG_WR]  = bg_age[2*NBG+bg_idx];
    sel_age[S_LR_ACT] = lr_age[0*NLR+lr_idx];
    sel_age[S_LR_RD]  = lr_age[1*NLR+lr_idx];
    sel_age[S_LR_WR]  = lr_age[2*NLR+lr_idx];
    sel_age[S_LR_REF] = lr_age[3*NLR+lr_idx];
    sel_age[S_PR_PRE] = pr_age[pr_idx];
  end

  logic [NUM_RULES-1:0][AW-1:0] lim;

  spc_limits #(.CW(CW), .LW(AW), .DATA_RATE(DATA_RATE)) u_limits (
    .t_rcd_i, .t_rp_i, .t_ras_i, .t_rrd_l_i, .t_rrd_s_i, .t_rtp_i,
    .t_wl_i, .bl_i, .t_wr_i, .t_wtr_l_i, .t_wtr_s_i,
    .t_ccd_l_i, .t_ccd_s_i, .t_ccd_l_wr_i, .t_ccd_s_wr_i,
    .t_rfc_i, .t_ppd_i, .lim_o(lim)
  );

  spc_rule_eval #(.AW(AW)) u_eval (
    .valid_i(cmd_valid_i), .cmd_i, .age_i(sel_age), .lim_i(lim),
    .viol_o, .rule_o
  );
endmodule

// File: rtl/spc_chk.sv
module spc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic [2:0] cmd_i,
  input logic       viol_o,
  input logic [4:0] rule_o
);
  logic prev_two_q, first_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_two_q <= 1'b0;
      first_q    <= 1'b1;
    end else begin
      prev_two_q <= cmd_valid_i && (cmd_i <= 3'd4);
      if (cmd_valid_i) first_q <= 1'b0;
    end
  end

  assert_bus_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && prev_two_q |-> viol_o && rule_o == 5'd1);
  assert_first_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && first_q |-> !viol_o);
  assert_code_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> rule_o != 5'd0 && rule_o <= 5'd18);
  assert_none_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !viol_o |-> rule_o == 5'd0);
  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |-> !viol_o);
endmodule

bind cmd_spacing_chk spc_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i),
  .cmd_i(cmd_i), .viol_o(viol_o), .rule_o(rule_o)
);

// File: tb/cmd_spacing_chk_tb.sv
`timescale 1ns/1ps
module cmd_spacing_chk_tb;
  localparam int ACT = 0, RD = 1, WR = 2, RDA = 3, WRA = 4, PPB = 5, PAB = 6, REF = 7;
  // limits derived from the configuration below
  localparam int L_RC = 12, L_RRDL = 5, L_RRDS = 3, L_RPA = 3, L_RDAA = 7, L_RFA = 19;
  localparam int L_RCD = 4, L_WTRL = 13, L_WTRS = 10, L_CCDL = 6, L_CCDS = 3;
  localparam int L_CCDLW = 7, L_CCDSW = 4, L_RASP = 9, L_RTPP = 4, L_WRP = 15, L_PPD = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_valid_i = 1'b0;
  logic [2:0] cmd_i = '0;
  logic [1:0] rank_i = '0;
  logic [0:0] bg_i = '0;
  logic [0:0] bank_i = '0;
  logic viol_o;
  logic [4:0] rule_o;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cmd_spacing_chk u_dut (
    .clk_i(clk), .rst_ni, .cmd_valid_i, .cmd_i, .rank_i, .bg_i, .bank_i,
    .t_rcd_i(8'd4), .t_rp_i(8'd4), .t_ras_i(8'd8), .t_rrd_l_i(8'd5), .t_rrd_s_i(8'd3),
    .t_rtp_i(8'd3), .t_wl_i(8'd4), .bl_i(8'd8), .t_wr_i(8'd6), .t_wtr_l_i(8'd5),
    .t_wtr_s_i(8'd2), .t_ccd_l_i(8'd6), .t_ccd_s_i(8'd3), .t_ccd_l_wr_i(8'd7),
    .t_ccd_s_wr_i(8'd4), .t_rfc_i(8'd20), .t_ppd_i(8'd3), .viol_o, .rule_o
  );

  task automatic chk(string tag, int exp);
    n_checks++;
    if (viol_o !== (exp != 0) || rule_o !== 5'(exp)) begin
      n_fail++;
      $display("FAIL %s: viol=%0b rule=%0d expected viol=%0b rule=%0d",
               tag, viol_o, rule_o, exp != 0, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); cmd_valid_i = 1'b0; rst_ni = 1'b0;
    @(negedge clk); @(negedge clk); rst_ni = 1'b1;
  endtask

  task automatic issue(int c, int rk, int g, int b);
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_i = 3'(c); rank_i = 2'(rk); bg_i = 1'(g); bank_i = 1'(b);
    #1;
  endtask

  task automatic idle();
    @(negedge clk); cmd_valid_i = 1'b0; #1;
  endtask

  task automatic pair(string tag, int ca, int ra, int ga, int ba,
                      int cb, int rb, int gb, int bb, int gap, int exp);
    do_reset();
    issue(ca, ra, ga, ba);
    repeat (gap - 1) idle();
    issue(cb, rb, gb, bb);
    chk(tag, exp);
    idle();
  endtask

  task automatic sweep(string tag, int ca, int ra, int ga, int ba,
                       int cb, int rb, int gb, int bb, int lo, int hi, int lim, int code);
    for (int g = lo; g <= hi; g++)
      pair(tag, ca, ra, ga, ba, cb, rb, gb, bb, g, (g < lim) ? code : 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    idle();
    chk("R10 reset state", 0);

    // R1 command bus
    pair("R1 ACT then RD other rank", ACT, 0, 0, 0, RD, 2, 1, 1, 1, 1);
    pair("R1 WRA then PREAB other rank", WRA, 0, 0, 0, PAB, 3, 0, 0, 1, 1);
    pair("R1 PREPB one slot", PPB, 0, 0, 0, ACT, 2, 0, 0, 1, 0);
    pair("R1 REFAB one slot", REF, 0, 0, 0, ACT, 3, 1, 1, 1, 0);
    pair("R1 bus outranks bank rule", ACT, 0, 0, 0, ACT, 0, 0, 0, 1, 1);

    // R2 ACT to ACT at each scope
    sweep("R2 same bank", ACT, 0, 0, 0, ACT, 0, 0, 0, 2, L_RC + 1, L_RC, 2);
    sweep("R2 same group", ACT, 0, 0, 0, ACT, 0, 0, 1, 2, L_RRDL + 1, L_RRDL, 3);
    sweep("R2 same logical rank", ACT, 0, 0, 0, ACT, 0, 1, 0, 2, L_RRDS + 1, L_RRDS, 4);
    sweep("R2 other logical rank", ACT, 0, 0, 0, ACT, 1, 0, 0, 2, 3, 0, 0);

    // R3 ACT after precharge, auto-precharge read, refresh
    sweep("R3 PREPB to ACT", PPB, 0, 0, 0, ACT, 0, 0, 0, 1, L_RPA + 1, L_RPA, 5);
    pair("R3 PREPB other bank", PPB, 0, 0, 0, ACT, 0, 0, 1, 1, 0);
    sweep("R3 RDA to ACT", RDA, 0, 1, 1, ACT, 0, 1, 1, 2, L_RDAA + 1, L_RDAA, 6);
    sweep("R3 REFAB to ACT", REF, 1, 0, 0, ACT, 1, 1, 1, 1, L_RFA + 1, L_RFA, 7);

    // R4 column command after ACT
    sweep("R4 ACT to RD", ACT, 0, 0, 0, RD, 0, 0, 0, 2, L_RCD + 1, L_RCD, 8);
    sweep("R4 ACT to WRA", ACT, 2, 1, 0, WRA, 2, 1, 0, 2, L_RCD + 1, L_RCD, 8);
    pair("R4 ACT other bank", ACT, 0, 0, 0, WR, 0, 0, 1, 2, 0);

    // R5 write to read, burst = 8/2
    sweep("R5 WR to RD same group", WR, 0, 0, 0, RD, 0, 0, 1, 2, L_WTRL + 1, L_WTRL, 9);
    sweep("R5 WRA to RDA other group", WRA, 0, 0, 0, RDA, 0, 1, 0, 2, L_WTRS + 1, L_WTRS, 10);
    pair("R5 WR other rank", WR, 0, 0, 0, RD, 1, 0, 0, 2, 0);

    // R6 read-read and write-write
    sweep("R6 RD to RD same group", RD, 0, 0, 0, RD, 0, 0, 1, 2, L_CCDL + 1, L_CCDL, 11);
    sweep("R6 RDA to RD other group", RDA, 0, 0, 0, RD, 0, 1, 1, 2, L_CCDS + 1, L_CCDS, 12);
    sweep("R6 WR to WRA same group", WR, 0, 0, 0, WRA, 0, 0, 1, 2, L_CCDLW + 1, L_CCDLW, 13);
    sweep("R6 WR to WR other group", WR, 0, 0, 0, WR, 0, 1, 0, 2, L_CCDSW + 1, L_CCDSW, 14);

    // R7 precharge after ACT, RD, WR on the bank
    sweep("R7 ACT to PREPB", ACT, 0, 0, 0, PPB, 0, 0, 0, 2, L_RASP + 1, L_RASP, 15);
    sweep("R7 RD to PREPB", RD, 0, 1, 0, PPB, 0, 1, 0, 2, L_RTPP + 1, L_RTPP, 16);
    sweep("R7 WR to PREPB", WR, 0, 0, 0, PPB, 0, 0, 0, 2, L_WRP + 1, L_WRP, 17);
    pair("R7 RDA not a read for PREPB", RDA, 0, 0, 0, PPB, 0, 0, 0, 2, 0);
    pair("R7 WRA not a write for PREPB", WRA, 0, 0, 0, PPB, 0, 0, 0, 2, 0);

    // R8 precharge spacing per physical rank (rank bit1 = physical)
    sweep("R8 PREPB to PREAB same phys", PPB, 0, 0, 0, PAB, 1, 0, 0, 1, L_PPD + 1, L_PPD, 18);
    pair("R8 PREAB to PREAB ranks 3,2", PAB, 3, 0, 0, PAB, 2, 0, 0, 1, 18);
    pair("R8 other physical rank", PAB, 1, 0, 0, PPB, 2, 0, 0, 1, 0);

    // R9 reset clears history
    do_reset();
    issue(ACT, 0, 0, 0);
    do_reset();
    issue(ACT, 0, 0, 0);
    chk("R9 history cleared by reset", 0);
    idle();
    // R9 saturation
    do_reset();
    issue(ACT, 0, 0, 0);
    repeat (1100) idle();
    issue(ACT, 0, 0, 0);
    chk("R9 saturated age", 0);
    idle();

    // R10 invalid cycles carry a code but do nothing
    do_reset();
    issue(ACT, 0, 0, 0);
    for (int i = 1; i < L_RC; i++) begin
      @(negedge clk); cmd_valid_i = 1'b0; cmd_i = 3'(ACT); #1;
      if (i <= 3) chk("R10 idle cycle no flag", 0);
    end
    issue(ACT, 0, 0, 0);
    chk("R10 idle cycles not recorded", 0);
    idle();

    // R11 violating ACT still recorded
    do_reset();
    issue(ACT, 0, 0, 0);
    idle();
    issue(ACT, 0, 0, 0);
    chk("R11 second ACT violates", 2);
    repeat (L_RC - 2) idle();
    issue(ACT, 0, 0, 0);
    chk("R11 timed from violating ACT", 2);
    idle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule